// File: doc/BRIEF.md
# Branch Target Buffer with Target Way Memory

This block is a direct-mapped branch target buffer for a single-issue, in-order fetch unit. Each entry holds the branch's partial tag, its target address and a one-bit taken prediction. It also records the instruction-cache way in which the target line was last found, together with a flag that says whether that record can still be trusted. A lookup is combinational, so the prediction and the way hint reach the instruction cache in the same fetch cycle with no extra stage.

When a lookup predicts taken and the recorded way is trusted, the block drives a one-hot way enable and tells the cache it may skip the tag comparison for the target fetch. In every other case all ways are enabled and the cache does a full lookup. After such a full lookup, the cache reports the branch PC and the way it resolved, and the entry stores that way. The cache also reports every line replacement as a set and way. Every entry whose target sits in that set and whose record points to that way loses its trusted flag in the same cycle.

Top module: `btb_way_hist`

## Requirements
- R1: After reset every entry is empty. A lookup then misses, predicts not taken, drives target 0, keeps `skip_tag_o` low and enables all ways.
- R2: A lookup hits when `lk_valid_i` is high, the entry at index PC[5:2] is filled, and its stored tag equals PC[13:6]. With `lk_valid_i` low there is no hit.
- R3: On a hit, `target_o` carries the stored target and `pred_taken_o` carries the stored taken bit, combinationally in the same cycle as the lookup. On a miss both are 0.
- R4: A resolution update writes the entry at its PC's index. If the entry already holds the same tag and the same target, only the taken bit changes and the way record is kept. Otherwise the entry is refilled with the new tag, target and taken bit, and its way record is marked untrusted.
- R5: A way report whose PC hits a filled entry at its index (same tag) stores the reported way and marks it trusted from the next cycle. A report whose PC does not hit changes nothing.
- R6: When a lookup predicts taken and the entry's way is trusted, `skip_tag_o` is 1 and `way_en_o` has exactly bit `way` set. Otherwise `skip_tag_o` is 0 and `way_en_o` is all ones.
- R7: An eviction notice (set, way) marks untrusted, within one cycle, every entry whose target set bits target[9:4] equal the set and whose recorded way equals the way. Entries that do not match are unaffected.
- R8: Same-cycle ordering on one entry: an update takes precedence over a way report, and an eviction that matches the entry's resulting target set and way wins over a way report.
- R9: An update with the taken bit 0 leaves a hit that predicts not taken, with no tag skip and all ways enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_pc_i | input | 32 | Fetch PC being looked up |
| hit_o | output | 1 | Lookup found a matching entry |
| pred_taken_o | output | 1 | Hit whose entry predicts taken |
| target_o | output | 32 | Predicted target address, 0 on miss |
| skip_tag_o | output | 1 | Cache may skip the tag check for the target |
| way_en_o | output | 4 | Cache way enables for the target fetch |
| upd_valid_i | input | 1 | Branch resolution update |
| upd_pc_i | input | 32 | Resolved branch PC |
| upd_target_i | input | 32 | Resolved branch target |
| upd_taken_i | input | 1 | Resolved direction |
| fb_valid_i | input | 1 | Way report from the cache after a full lookup |
| fb_pc_i | input | 32 | Branch PC the report belongs to |
| fb_way_i | input | 2 | Way where the target line was found |
| ev_valid_i | input | 1 | Cache line replacement notice |
| ev_set_i | input | 6 | Set of the replaced line |
| ev_way_i | input | 2 | Way of the replaced line |

## Verification
The assertions take for granted that every request input is a known value whenever reset is released. They also assume that a way report names a branch PC exactly as the update for that branch did, and that the set and way of an eviction describe one real cache line. The stimulus drives all inputs once per cycle on the falling edge, draws PCs and targets from small pools so that index aliasing, repeated hits and set collisions occur often, and keeps every way value inside the four-way range. Directed sequences put way reports, evictions and updates on the same entry in the same cycle.

// File: rtl/btb_wh_pkg.sv
package btb_wh_pkg;
  parameter int unsigned ENTRIES    = 16;
  parameter int unsigned PC_W       = 32;
  parameter int unsigned TAG_W      = 8;
  parameter int unsigned WAYS       = 4;
  parameter int unsigned SET_W      = 6;
  parameter int unsigned LINE_OFF_W = 4;
  parameter int unsigned IDX_LSB    = 2;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [PC_W-1:0]  target;
    logic             taken;
    logic [WAY_W-1:0] way;
    logic             way_valid;
  } entry_t;
endpackage

// File: rtl/btb_wh_entry.sv
module btb_wh_entry
  import btb_wh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_sel_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic             upd_taken_i,
  input  logic             fb_sel_i,
  input  logic [TAG_W-1:0] fb_tag_i,
  input  logic [WAY_W-1:0] fb_way_i,
  input  logic             ev_valid_i,
  input  logic [SET_W-1:0] ev_set_i,
  input  logic [WAY_W-1:0] ev_way_i,
  output entry_t           entry_o
);
  entry_t q, d;
  logic same_br, fb_hit, ev_hit;

  always_comb begin
    d       = q;
    same_br = q.valid && (q.tag == upd_tag_i) && (q.target == upd_target_i);
    fb_hit  = fb_sel_i && q.valid && (q.tag == fb_tag_i);
    if (upd_sel_i) begin
      if (same_br) begin
        d.taken = upd_taken_i;
      end else begin
        d.valid     = 1'b1;
        d.tag       = upd_tag_i;
        d.target    = upd_target_i;
        d.taken     = upd_taken_i;
        d.way       = '0;
        d.way_valid = 1'b0;
      end
    end else if (fb_hit) begin
      d.way       = fb_way_i;
      d.way_valid = 1'b1;
    end
    // eviction is applied last so it overrides a same-cycle way report
    ev_hit = ev_valid_i && (d.target[LINE_OFF_W +: SET_W] == ev_set_i) && (d.way == ev_way_i);
    if (ev_hit) d.way_valid = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign entry_o = q;

  assert_alloc_clears_way_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_sel_i && !(q.valid && q.tag == upd_tag_i && q.target == upd_target_i)) |=> !q.way_valid);

  assert_fb_sets_way_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i && !upd_sel_i && q.valid && q.tag == fb_tag_i && !ev_valid_i)
      |=> (q.way_valid && q.way == $past(fb_way_i)));

  assert_evict_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !upd_sel_i && !fb_sel_i && q.way_valid &&
     q.target[LINE_OFF_W +: SET_W] == ev_set_i && q.way == ev_way_i) |=> !q.way_valid);

  assert_evict_beats_fb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i && !upd_sel_i && q.valid && q.tag == fb_tag_i && ev_valid_i &&
     q.target[LINE_OFF_W +: SET_W] == ev_set_i && fb_way_i == ev_way_i) |=> !q.way_valid);
endmodule

// File: rtl/btb_wh_lookup.sv
module btb_wh_lookup
  import btb_wh_pkg::*;
(
  input  logic             lk_valid_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  entry_t           entry_i,
  output logic             hit_o,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  target_o,
  output logic             skip_tag_o,
  output logic [WAYS-1:0]  way_en_o
);
  assign hit_o        = lk_valid_i && entry_i.valid && (entry_i.tag == lk_tag_i);
  assign pred_taken_o = hit_o && entry_i.taken;
  assign target_o     = hit_o ? entry_i.target : '0;
  assign skip_tag_o   = pred_taken_o && entry_i.way_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way_en
    assign way_en_o[w] = !skip_tag_o || (entry_i.way == WAY_W'(w));
  end
endmodule

// File: rtl/btb_way_hist.sv
module btb_way_hist
  import btb_wh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             hit_o,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  target_o,
  output logic             skip_tag_o,
  output logic [WAYS-1:0]  way_en_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic             upd_taken_i,
  input  logic             fb_valid_i,
  input  logic [PC_W-1:0]  fb_pc_i,
  input  logic [WAY_W-1:0] fb_way_i,
  input  logic             ev_valid_i,
  input  logic [SET_W-1:0] ev_set_i,
  input  logic [WAY_W-1:0] ev_way_i
);
  entry_t [ENTRIES-1:0] ents;

  logic [IDX_W-1:0] lk_idx, upd_idx, fb_idx;
  assign lk_idx  = lk_pc_i [IDX_LSB +: IDX_W];
  assign upd_idx = upd_pc_i[IDX_LSB +: IDX_W];
  assign fb_idx  = fb_pc_i [IDX_LSB +: IDX_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    btb_wh_entry u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_sel_i   (upd_valid_i && (upd_idx == IDX_W'(i))),
      .upd_tag_i   (upd_pc_i[TAG_LSB +: TAG_W]),
      .upd_target_i(upd_target_i),
      .upd_taken_i (upd_taken_i),
      .fb_sel_i    (fb_valid_i && (fb_idx == IDX_W'(i))),
      .fb_tag_i    (fb_pc_i[TAG_LSB +: TAG_W]),
      .fb_way_i    (fb_way_i),
      .ev_valid_i  (ev_valid_i),
      .ev_set_i    (ev_set_i),
      .ev_way_i    (ev_way_i),
      .entry_o     (ents[i])
    );
  end

  btb_wh_lookup u_lookup (
    .lk_valid_i  (lk_valid_i),
    .lk_tag_i    (lk_pc_i[TAG_LSB +: TAG_W]),
    .entry_i     (ents[lk_idx]),
    .hit_o       (hit_o),
    .pred_taken_o(pred_taken_o),
    .target_o    (target_o),
    .skip_tag_o  (skip_tag_o),
    .way_en_o    (way_en_o)
  );

  assert_idle_no_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !hit_o);

  assert_skip_needs_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_tag_o |-> (hit_o && pred_taken_o));

  assert_skip_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_tag_o |-> ($countones(way_en_o) == 1));

  assert_full_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_tag_o |-> (&way_en_o));

  assert_not_taken_no_skip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pred_taken_o) |-> !skip_tag_o);
endmodule

// File: tb/tb_btb_way_hist.sv
module tb_btb_way_hist;
  import btb_wh_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0;
  logic lk_valid_i = 0, upd_valid_i = 0, upd_taken_i = 0, fb_valid_i = 0, ev_valid_i = 0;
  logic [PC_W-1:0] lk_pc_i = '0, upd_pc_i = '0, upd_target_i = '0, fb_pc_i = '0;
  logic [WAY_W-1:0] fb_way_i = '0, ev_way_i = '0;
  logic [SET_W-1:0] ev_set_i = '0;
  logic hit_o, pred_taken_o, skip_tag_o;
  logic [PC_W-1:0] target_o;
  logic [WAYS-1:0] way_en_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_way_hist dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
    .hit_o(hit_o), .pred_taken_o(pred_taken_o), .target_o(target_o),
    .skip_tag_o(skip_tag_o), .way_en_o(way_en_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_target_i(upd_target_i),
    .upd_taken_i(upd_taken_i),
    .fb_valid_i(fb_valid_i), .fb_pc_i(fb_pc_i), .fb_way_i(fb_way_i),
    .ev_valid_i(ev_valid_i), .ev_set_i(ev_set_i), .ev_way_i(ev_way_i)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // reference model: one record per index
  bit   m_v [16];
  int   m_tag [16];
  logic [31:0] m_tgt [16];
  bit   m_tk [16];
  int   m_wy [16];
  bit   m_wv [16];

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int idx, tg;
    bit e_hit, e_tk, e_skip;
    logic [31:0] e_tgt;
    logic [3:0] e_en;
    idx = int'(lk_pc_i[5:2]);
    tg  = int'(lk_pc_i[13:6]);
    e_hit  = lk_valid_i && m_v[idx] && (m_tag[idx] == tg);
    e_tk   = e_hit && m_tk[idx];
    e_tgt  = e_hit ? m_tgt[idx] : 32'h0;
    e_skip = e_tk && m_wv[idx];
    e_en   = e_skip ? (4'b1 << m_wy[idx]) : 4'hf;
    chk("R2 hit", hit_o, e_hit);
    chk("R3 pred_taken", pred_taken_o, e_tk);
    chk("R3 target", target_o, e_tgt);
    chk("R6 skip_tag", skip_tag_o, e_skip);
    chk("R6 way_en", way_en_o, e_en);
  endtask

  task automatic model_step();
    int ui, fi;
    ui = int'(upd_pc_i[5:2]);
    fi = int'(fb_pc_i[5:2]);
    if (fb_valid_i && !(upd_valid_i && ui == fi) && m_v[fi] && m_tag[fi] == int'(fb_pc_i[13:6])) begin
      m_wy[fi] = int'(fb_way_i);
      m_wv[fi] = 1;
    end
    if (upd_valid_i) begin
      if (m_v[ui] && m_tag[ui] == int'(upd_pc_i[13:6]) && m_tgt[ui] == upd_target_i) begin
        m_tk[ui] = upd_taken_i;
      end else begin
        m_v[ui] = 1; m_tag[ui] = int'(upd_pc_i[13:6]); m_tgt[ui] = upd_target_i;
        m_tk[ui] = upd_taken_i; m_wy[ui] = 0; m_wv[ui] = 0;
      end
    end
    if (ev_valid_i)
      for (int i = 0; i < 16; i++)
        if (int'(m_tgt[i][9:4]) == int'(ev_set_i) && m_wy[i] == int'(ev_way_i)) m_wv[i] = 0;
  endtask

  // called at a falling edge with inputs driven
  task automatic cycle();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid_i = 0; upd_valid_i = 0; fb_valid_i = 0; ev_valid_i = 0;
  endtask

  function automatic logic [31:0] mk_pc(int tg, int idx);
    return (32'(tg) << 6) | (32'(idx) << 2);
  endfunction

  function automatic logic [31:0] mk_tgt(int hi, int set, int w);
    return (32'(hi) << 10) | (32'(set) << 4) | (32'(w) << 2);
  endfunction

  task automatic look(logic [31:0] pc);
    idle(); lk_valid_i = 1; lk_pc_i = pc; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, ta, tb2;
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_tk[i] = 0; m_wy[i] = 0; m_wv[i] = 0;
    end
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    cur_req = "R1";
    look(mk_pc(0, 1)); look(mk_pc(3, 7));

    pa = mk_pc(1, 1); ta = mk_tgt(1, 5, 0);
    cur_req = "R4";
    idle(); upd_valid_i = 1; upd_pc_i = pa; upd_target_i = ta; upd_taken_i = 1; cycle();
    look(pa);                                   // hit, taken, no skip yet
    cur_req = "R5";
    idle(); fb_valid_i = 1; fb_pc_i = pa; fb_way_i = 2; cycle();
    cur_req = "R6";
    look(pa);                                   // skip, way_en 0100
    cur_req = "R5";
    idle(); fb_valid_i = 1; fb_pc_i = mk_pc(2, 1); fb_way_i = 3; cycle();
    look(pa);                                   // unchanged
    cur_req = "R9";
    idle(); upd_valid_i = 1; upd_pc_i = pa; upd_target_i = ta; upd_taken_i = 0; cycle();
    look(pa);
    cur_req = "R4";
    idle(); upd_valid_i = 1; upd_pc_i = pa; upd_target_i = ta; upd_taken_i = 1; cycle();
    look(pa);                                   // way kept
    cur_req = "R7";
    idle(); ev_valid_i = 1; ev_set_i = 5; ev_way_i = 1; cycle();
    look(pa);                                   // other way: still skip
    idle(); ev_valid_i = 1; ev_set_i = 6; ev_way_i = 2; cycle();
    look(pa);                                   // other set: still skip
    idle(); ev_valid_i = 1; ev_set_i = 5; ev_way_i = 2; cycle();
    look(pa);                                   // cleared
    cur_req = "R8";
    idle(); fb_valid_i = 1; fb_pc_i = pa; fb_way_i = 3;
    ev_valid_i = 1; ev_set_i = 5; ev_way_i = 3; cycle();
    look(pa);
    pb = mk_pc(0, 4); tb2 = mk_tgt(0, 5, 1);
    idle(); upd_valid_i = 1; upd_pc_i = pb; upd_target_i = tb2; upd_taken_i = 1; cycle();
    idle(); fb_valid_i = 1; fb_pc_i = pa; fb_way_i = 0; cycle();
    idle(); fb_valid_i = 1; fb_pc_i = pb; fb_way_i = 0; cycle();
    cur_req = "R7";
    look(pa); look(pb);
    idle(); ev_valid_i = 1; ev_set_i = 5; ev_way_i = 0; cycle();
    look(pa); look(pb);                         // both cleared together
    cur_req = "R8";
    idle(); fb_valid_i = 1; fb_pc_i = pa; fb_way_i = 1;
    upd_valid_i = 1; upd_pc_i = pa; upd_target_i = mk_tgt(0, 2, 0); upd_taken_i = 1; cycle();
    look(pa);
    cur_req = "R2";
    look(mk_pc(5, 1));
    idle(); lk_pc_i = pa; cycle();

    cur_req = "random";
    for (int n = 0; n < 4000; n++) begin
      idle();
      lk_valid_i = ($urandom_range(0, 3) != 0);
      lk_pc_i = mk_pc($urandom_range(0, 2), $urandom_range(0, 3));
      upd_valid_i = ($urandom_range(0, 4) == 0);
      upd_pc_i = mk_pc($urandom_range(0, 2), $urandom_range(0, 3));
      upd_target_i = mk_tgt($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1));
      upd_taken_i = ($urandom_range(0, 3) != 0);
      fb_valid_i = ($urandom_range(0, 2) == 0);
      fb_pc_i = mk_pc($urandom_range(0, 2), $urandom_range(0, 3));
      fb_way_i = WAY_W'($urandom_range(0, 3));
      ev_valid_i = ($urandom_range(0, 5) == 0);
      ev_set_i = SET_W'($urandom_range(0, 3));
      ev_way_i = WAY_W'($urandom_range(0, 3));
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule